// File: doc/BRIEF.md
# Parallel ADC FIFO Burst Reader

This block sits on the host side of a parallel bus that connects to a sampling converter with an internal result FIFO. It watches the converter's data-available line. Each new assertion of that line starts one burst, which fetches a fixed number of words through chip-select and read strobes. Every word is tagged with the channel it belongs to, and the words leave the block as a one-cycle-valid stream. The last word of each burst is marked.

The converter can take either one combined read/write strobe or separate read and write strobes, and a mode input selects which one the block drives. In combined mode every read is framed by its own chip-select window. In separate mode the chip select is held low for the whole burst, and only the read strobe toggles. The converter's second chip select, which is active high, is held asserted at all times.

A new data-available edge can arrive before the burst has finished. The block then abandons the burst, pulses the converter's FIFO reset so that the word-to-channel alignment is restored, and sets a sticky overrun flag. Setup, strobe, hold and reset widths are parameter cycle counts.

Top module: `adc_burst_reader`

## Requirements
- R1: After reset, csLowN, rdN, wrN and rdWrN are 1, csHigh is 1, and fifoRst, overrun, outValid and outLast are 0.
- R2: csHigh is held at 1 and wrN is held at 1 at all times, because the block never writes.
- R3: With combinedMode=1, each read works as follows. csLowN goes low SETUP_CYC cycles before rdWrN goes low. rdWrN stays low for exactly STROBE_CYC cycles. csLowN stays low for HOLD_CYC cycles after rdWrN returns high, and then goes high between words. rdN stays at 1.
- R4: With combinedMode=0, the following hold. csLowN goes low SETUP_CYC cycles before the first rdN low. csLowN stays low without a break until HOLD_CYC cycles after the last strobe. rdN is low for STROBE_CYC cycles per word, with HOLD_CYC high cycles between words. rdWrN stays at 1.
- R5: A rising edge on dataAvail, passed through a two-flop synchronizer, starts exactly one burst of BURST_LEN reads. Holding dataAvail high after the burst starts no further reads.
- R6: Each word is taken from busData on the last cycle that the strobe is low. It appears on outData with a one-cycle outValid pulse in the following cycle.
- R7: Word k of a burst (k counted from 0) carries outChan = k mod CH_NUM. outLast is 1 only together with the word k = BURST_LEN-1.
- R8: A rising dataAvail edge that arrives while a burst is in progress aborts the burst. fifoRst is then high for exactly RST_CYC cycles, and during that time csLowN, rdN and rdWrN are all 1. No further words of the aborted burst are output, and the block then returns to idle.
- R9: An abort sets overrun. overrun stays at 1 until ovrClr is sampled high. If the abort and ovrClr fall in the same cycle, overrun is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| combinedMode | input | 1 | 1: single read/write strobe, 0: separate strobes |
| dataAvail | input | 1 | Converter FIFO trigger-level line (asynchronous) |
| busData | input | DATA_W | Converter data bus |
| ovrClr | input | 1 | Clears the overrun flag |
| csLowN | output | 1 | Active-low chip select |
| csHigh | output | 1 | Active-high chip select, held at 1 |
| rdN | output | 1 | Read strobe for separate mode, active low |
| wrN | output | 1 | Write strobe for separate mode, held inactive |
| rdWrN | output | 1 | Combined read/write strobe, low during a read |
| fifoRst | output | 1 | FIFO reset pulse to the converter |
| overrun | output | 1 | Sticky overrun flag |
| outValid | output | 1 | Output word valid, one cycle per word |
| outData | output | DATA_W | Sampled word |
| outChan | output | CH_W | Channel tag of the word |
| outLast | output | 1 | Marks the final word of a burst |

## Verification
Some properties are checked on every cycle: only the strobe chosen by the mode ever goes low, a strobe is never low without csLowN low, the bus stays quiet while fifoRst is high, a reset pulse is always paired with overrun, overrun stays set until cleared, and outValid never lasts more than one cycle. Other behaviour only shows over whole bench scenarios. These are the exact setup, strobe and hold widths, csLowN being held through a burst in separate mode, one burst per dataAvail edge with the right word count, correct data and round-robin channel tags, the length of the reset pulse, no stray words after an abort, and clean recovery on the next burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_GAP,
    ST_RESET
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic newBurst;  // restart channel counting
    logic capture;   // take busData this cycle
    logic lastWord;  // the word being captured ends the burst
  } dpCmd_t;

endpackage

// File: rtl/burst_dp.sv
module burst_dp #(
  parameter int DATA_W = 12,
  parameter int CH_NUM = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataAvail,
  input  logic [DATA_W-1:0] busData,
  input  burst_pkg::dpCmd_t cmd,
  output logic              startPulse,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CH_W-1:0]   outChan,
  output logic              outLast
);

  localparam logic [CH_W-1:0] CH_MAX = CH_W'(CH_NUM - 1);

  logic syncA, syncB, syncPrev;
  logic [CH_W-1:0] chanCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= dataAvail;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign startPulse = syncB & ~syncPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanCnt  <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outChan  <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= cmd.capture;
      outLast  <= cmd.capture & cmd.lastWord;
      if (cmd.newBurst) begin
        chanCnt <= '0;
      end else if (cmd.capture) begin
        outData <= busData;
        outChan <= chanCnt;
        chanCnt <= (chanCnt == CH_MAX) ? '0 : chanCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
  parameter int BURST_LEN  = 8,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int RST_CYC    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              combinedMode,
  input  logic              startPulse,
  input  logic              ovrClr,
  output burst_pkg::dpCmd_t cmd,
  output logic              csLowN,
  output logic              rdN,
  output logic              rdWrN,
  output logic              fifoRst,
  output logic              overrun
);
  import burst_pkg::*;

  localparam int MAX_A  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B  = (HOLD_CYC > RST_CYC) ? HOLD_CYC : RST_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int IDX_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST_LEN - 1);

  rdState_t state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] wordIdx;
  logic busy, abortNow;

  assign busy     = (state == ST_SETUP) || (state == ST_STROBE) ||
                    (state == ST_HOLD)  || (state == ST_GAP);
  assign abortNow = startPulse & busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wordIdx <= '0;
      overrun <= 1'b0;
    end else begin
      if (ovrClr) overrun <= 1'b0;
      if (abortNow) begin
        state   <= ST_RESET;
        cnt     <= '0;
        overrun <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (startPulse) begin
            state   <= ST_SETUP;
            cnt     <= '0;
            wordIdx <= '0;
          end
          ST_SETUP: begin
            if (cnt == CNT_W'(SETUP_CYC - 1)) begin
              state <= ST_STROBE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_STROBE: begin
            if (cnt == CNT_W'(STROBE_CYC - 1)) begin
              state <= ST_HOLD;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_HOLD: begin
            if (cnt == CNT_W'(HOLD_CYC - 1)) begin
              cnt <= '0;
              if (wordIdx == IDX_LAST) begin
                state <= ST_IDLE;
              end else begin
                wordIdx <= wordIdx + 1'b1;
                state   <= combinedMode ? ST_GAP : ST_STROBE;
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_GAP: begin
            state <= ST_SETUP;
            cnt   <= '0;
          end
          ST_RESET: begin
            if (cnt == CNT_W'(RST_CYC - 1)) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  logic strobeOn;
  assign strobeOn = (state == ST_STROBE);

  always_comb begin
    cmd.newBurst = (state == ST_IDLE) & startPulse;
    cmd.capture  = strobeOn & (cnt == CNT_W'(STROBE_CYC - 1)) & ~abortNow;
    cmd.lastWord = (wordIdx == IDX_LAST);
  end

  assign csLowN  = ~((state == ST_SETUP) | strobeOn | (state == ST_HOLD));
  assign rdN     = ~(strobeOn & ~combinedMode);
  assign rdWrN   = ~(strobeOn & combinedMode);
  assign fifoRst = (state == ST_RESET);

endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader #(
  parameter int DATA_W     = 12,
  parameter int CH_NUM     = 4,
  parameter int BURST_LEN  = 8,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int RST_CYC    = 3,
  localparam int CH_W      = (CH_NUM > 1) ? $clog2(CH_NUM) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              combinedMode,
  input  logic              dataAvail,
  input  logic [DATA_W-1:0] busData,
  input  logic              ovrClr,
  output logic              csLowN,
  output logic              csHigh,
  output logic              rdN,
  output logic              wrN,
  output logic              rdWrN,
  output logic              fifoRst,
  output logic              overrun,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CH_W-1:0]   outChan,
  output logic              outLast
);

  burst_pkg::dpCmd_t cmd;
  logic startPulse;

  assign csHigh = 1'b1;
  assign wrN    = 1'b1;

  burst_ctrl #(
    .BURST_LEN(BURST_LEN), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .combinedMode(combinedMode),
    .startPulse(startPulse), .ovrClr(ovrClr), .cmd(cmd),
    .csLowN(csLowN), .rdN(rdN), .rdWrN(rdWrN),
    .fifoRst(fifoRst), .overrun(overrun)
  );

  burst_dp #(.DATA_W(DATA_W), .CH_NUM(CH_NUM), .CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .dataAvail(dataAvail), .busData(busData),
    .cmd(cmd), .startPulse(startPulse), .outValid(outValid),
    .outData(outData), .outChan(outChan), .outLast(outLast)
  );

endmodule

// File: rtl/adc_burst_reader_chk.sv
module adc_burst_reader_chk (
  input logic clk,
  input logic rstN,
  input logic combinedMode,
  input logic ovrClr,
  input logic csLowN,
  input logic rdN,
  input logic rdWrN,
  input logic fifoRst,
  input logic overrun,
  input logic outValid,
  input logic outLast
);

  a_r3_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !rdWrN) |-> !csLowN);

  a_r3_combined_rd_idle: assert property (@(posedge clk) disable iff (!rstN)
    combinedMode |-> rdN);

  a_r4_separate_rw_idle: assert property (@(posedge clk) disable iff (!rstN)
    !combinedMode |-> rdWrN);

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  a_r8_reset_bus_quiet: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |-> (csLowN && rdN && rdWrN));

  a_r8_reset_no_words: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |-> !outValid);

  a_r9_reset_flags_overrun: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoRst) |-> overrun);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovrClr) |=> overrun);

endmodule

bind adc_burst_reader adc_burst_reader_chk u_chk (
  .clk(clk), .rstN(rstN), .combinedMode(combinedMode), .ovrClr(ovrClr),
  .csLowN(csLowN), .rdN(rdN), .rdWrN(rdWrN), .fifoRst(fifoRst),
  .overrun(overrun), .outValid(outValid), .outLast(outLast)
);

// File: tb/adc_burst_reader_test.sv
`timescale 1ns/1ps
module adc_burst_reader_test;

  localparam int DATA_W = 12, CH_NUM = 4, BURST_LEN = 8;
  localparam int SETUP_CYC = 1, STROBE_CYC = 2, HOLD_CYC = 1, RST_CYC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0, combinedMode = 1'b1, dataAvail = 1'b0, ovrClr = 1'b0;
  logic [DATA_W-1:0] busData = '0;
  logic csLowN, csHigh, rdN, wrN, rdWrN, fifoRst, overrun;
  logic outValid, outLast;
  logic [DATA_W-1:0] outData;
  logic [1:0] outChan;

  always #4 clk = ~clk;

  adc_burst_reader #(
    .DATA_W(DATA_W), .CH_NUM(CH_NUM), .BURST_LEN(BURST_LEN),
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC),
    .RST_CYC(RST_CYC)
  ) uut (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [DATA_W-1:0] mem [BURST_LEN];
  int k = 0, rdPtr = 0, strobeNum = 0, csRises = 0, kAbort = -1, resets = 0;
  bit started = 0, abortTest = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expChan(input int idx);
    return idx % CH_NUM;
  endfunction

  // Converter model plus pin monitor, evaluated at the falling edge
  logic prevStrb = 1'b1, prevCs = 1'b1, prevFr = 1'b0;
  int csLowRun = 0, strbLowRun = 0, highRun = 0, frRun = 0;
  always @(negedge clk) begin
    logic strb, other;
    cycles++;
    if (started) begin
      strb  = combinedMode ? rdWrN : rdN;
      other = combinedMode ? rdN : rdWrN;
      if (!strb && prevStrb) begin
        if (combinedMode || strobeNum == 0)
          chk(csLowRun == SETUP_CYC, combinedMode ? "R3 setup" : "R4 setup", csLowRun, SETUP_CYC);
        if (!combinedMode && strobeNum > 0)
          chk(highRun == HOLD_CYC, "R4 gap", highRun, HOLD_CYC);
        chk(other == 1'b1, combinedMode ? "R3 rdN idle" : "R4 rdWrN idle", other, 1);
        chk(csHigh && wrN, "R2 csHigh/wrN", {csHigh, wrN}, 3);
        strobeNum++;
      end
      if (strb && !prevStrb) begin
        chk(strbLowRun == STROBE_CYC, "R3/R4 strobe width", strbLowRun, STROBE_CYC);
        rdPtr++;
      end
      if (csLowN && !prevCs && !fifoRst && !abortTest) begin
        chk(highRun == HOLD_CYC, "R3/R4 hold", highRun, HOLD_CYC);
        csRises++;
      end
      if (fifoRst) begin
        chk(csLowN && rdN && rdWrN, "R8 quiet bus", {csLowN, rdN, rdWrN}, 7);
        if (!prevFr) begin
          chk(overrun == 1'b1, "R9 set on abort", overrun, 1);
          kAbort = k;
          resets++;
        end
      end
      if (!fifoRst && prevFr)
        chk(frRun == RST_CYC, "R8 reset width", frRun, RST_CYC);
      if (outValid) begin
        if (k < BURST_LEN) begin
          chk(outData == mem[k], "R6 data", outData, mem[k]);
          chk(outChan == expChan(k), "R7 chan", outChan, expChan(k));
          chk(outLast == (k == BURST_LEN - 1), "R7 last", outLast, k == BURST_LEN - 1);
        end
        k++;
      end
      csLowRun   = csLowN ? 0 : csLowRun + 1;
      strbLowRun = strb ? 0 : strbLowRun + 1;
      highRun    = strb ? highRun + 1 : 0;
      frRun      = fifoRst ? frRun + 1 : 0;
      prevStrb = strb;
      prevCs   = csLowN;
      prevFr   = fifoRst;
      if (!csLowN && !strb && rdPtr < BURST_LEN) busData <= mem[rdPtr];
      else busData <= DATA_W'($urandom);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic armBurst(input bit mode);
    tick(1);
    combinedMode = mode;
    for (int i = 0; i < BURST_LEN; i++) mem[i] = DATA_W'($urandom);
    k = 0; rdPtr = 0; strobeNum = 0; csRises = 0; kAbort = -1;
  endtask

  task automatic runBurst(input bit mode);
    int t;
    armBurst(mode);
    dataAvail = 1'b1;
    t = 0;
    while (k < BURST_LEN && t < 400) begin tick(1); t++; end
    tick(5 + ($urandom % 20));   // line held high: no new burst (R5)
    dataAvail = 1'b0;
    tick(8);
    chk(k == BURST_LEN, "R5 words per burst", k, BURST_LEN);
    chk(strobeNum == BURST_LEN, "R5 reads per burst", strobeNum, BURST_LEN);
    chk(csRises == (mode ? BURST_LEN : 1), mode ? "R3 cs per word" : "R4 cs held",
        csRises, mode ? BURST_LEN : 1);
  endtask

  task automatic abortBurst(input bit mode, input bit clrHeld);
    int t, r0;
    abortTest = 1;
    r0 = resets;
    armBurst(mode);
    ovrClr = clrHeld;
    dataAvail = 1'b1;
    t = 0;
    while (k < 3 && t < 400) begin tick(1); t++; end
    dataAvail = 1'b0;
    tick(3);
    dataAvail = 1'b1;
    tick(40);
    dataAvail = 1'b0;
    chk(resets == r0 + 1, "R8 one reset pulse", resets - r0, 1);
    chk(k == kAbort && k < BURST_LEN, "R8 no words after abort", k, kAbort);
    ovrClr = 1'b0;
    tick(3);
    if (!clrHeld) begin
      chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
      ovrClr = 1'b1; tick(1); ovrClr = 1'b0; tick(1);
    end
    chk(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
    tick(5);
    abortTest = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    chk(csLowN && rdN && rdWrN && wrN, "R1 strobes idle", {csLowN, rdN, rdWrN, wrN}, 15);
    chk(csHigh == 1'b1, "R1 csHigh", csHigh, 1);
    chk(!fifoRst && !overrun, "R1 reset/overrun", {fifoRst, overrun}, 0);
    chk(!outValid && !outLast, "R1 stream idle", {outValid, outLast}, 0);
    rstN = 1'b1;
    started = 1;
    tick(4);
    runBurst(1'b1);
    runBurst(1'b0);
    abortBurst(1'b1, 1'b0);
    runBurst(1'b1);           // recovery after reset
    abortBurst(1'b0, 1'b1);   // clear held high: set wins
    runBurst(1'b0);
    for (int n = 0; n < 20; n++) begin
      tick($urandom % 10);
      runBurst(1'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    chk(1'b0, "watchdog", cycles, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule